// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns the system clock into a one-cycle execution enable pulse whose average rate is the system clock divided by a fixed-point divisor with a 16-bit whole part and an 8-bit fraction. A state machine downstream runs one step on every cycle in which the pulse is high, so a divisor of 2.5 gives it two steps in every five system cycles, spread as evenly as the fraction allows.

The divider is a phase accumulator kept in units of 1/256 of a cycle. It advances on every clock whether or not the attached state machine is enabled; the enable input only masks the pulse that leaves the block. A restart strobe returns the phase to zero, so several copies given equal divisors and restarted in the same cycle emit identical pulse trains from then on. The divisor may be rewritten at any time, and a later common restart brings the copies back into step. The phase register is brought out for observation.

Internally a two-state sequencer holds the pulse: PH_ACCUM (no pulse this cycle) and PH_FIRE (pulse this cycle). Reset or restart moves it to PH_ACCUM; otherwise it moves to PH_FIRE when the advanced phase reaches the divisor and to PH_ACCUM when it does not.

Top module: `frac_clken_div`

## Requirements
- R1: While `rst` is high, and after the first rising edge with `rst` high, `phase` is 0 and `tick` is 0.
- R2: The divisor value D is `div_int`*256 + `div_frac`. On each rising edge without reset or restart, with S = `phase` + 256: if S >= D then `phase` becomes S - D and the pulse is raised for the following cycle, otherwise `phase` becomes S and the pulse is low.
- R3: A `div_int` of 0 means a whole part of 65536 with the fraction taken as 0 whatever `div_frac` holds, so from phase zero the first pulse comes exactly 65536 cycles later.
- R4: A divisor of exactly 1.0 (`div_int`=1, `div_frac`=0) gives a pulse on every cycle and keeps `phase` at 0.
- R5: `sm_en` low forces `tick` low but leaves the phase sequence unchanged; `tick` equals the internal pulse ANDed with `sm_en`.
- R6: `restart` high at a rising edge sets `phase` to 0 and `tick` to 0 for the next cycle, taking priority over a pulse the accumulator would have produced.
- R7: Two instances with equal divisor and enable, restarted in the same cycle, produce identical `tick` and `phase` on every later cycle regardless of their earlier history.
- R8: A divisor change takes effect at the next rising edge without a restart; the phase carries over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_int | input | INT_W (16) | Whole part of the divisor, 0 meaning 65536 |
| div_frac | input | FRAC_W (8) | Fractional part of the divisor in 1/256 units |
| restart | input | 1 | Strobe that returns the phase to zero |
| sm_en | input | 1 | State-machine enable, masks the output pulse only |
| tick | output | 1 | One-cycle execution enable pulse |
| phase | output | INT_W+FRAC_W (24) | Accumulated phase in 1/256 cycle units |

## Verification
The bench targets the zero whole part with a nonzero fraction: a design that honoured the fraction there would miss the pulse at cycle 65536, and one that treated zero as zero would pulse every cycle. It runs fractional divisors such as 1.5 and 2.5, where a truncating design drifts from the expected phase within a few cycles, and disables the enable mid-run, where a design that froze the accumulator would resume with the wrong phase. A restart during a would-be pulse catches a design that lets the pulse through, and a second instance restarted alongside the first exposes any history left in the phase after restart.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Pulse sequencer states.
    typedef enum logic {
        PH_ACCUM = 1'b0,
        PH_FIRE  = 1'b1
    } ph_state_e;

endpackage

// File: rtl/clkdiv_norm.sv
// Maps the divisor fields onto one value in 1/256 units; a zero whole part
// selects the full-range divisor and drops the fraction.
module clkdiv_norm #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    localparam int DIV_W = INT_W + FRAC_W + 1
) (
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [DIV_W-1:0]  divisor
);

    localparam logic [DIV_W-1:0] FULL_RANGE = DIV_W'(1) << (INT_W + FRAC_W);

    always_comb begin
        if (div_int == '0) begin
            divisor = FULL_RANGE;
        end else begin
            divisor = {1'b0, div_int, div_frac};
        end
    end

endmodule

// File: rtl/clkdiv_accum.sv
// Phase accumulator: advances by one whole cycle per clock and wraps by the
// divisor, reporting when a wrap happens.
module clkdiv_accum #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    localparam int ACC_W = INT_W + FRAC_W,
    localparam int DIV_W = ACC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic [ACC_W-1:0] phase,
    output logic             wrap
);

    localparam logic [DIV_W-1:0] STEP = DIV_W'(1) << FRAC_W;

    logic [DIV_W-1:0] advanced;
    logic [DIV_W-1:0] reduced;
    logic [ACC_W-1:0] phase_d;

    always_comb begin
        advanced = {1'b0, phase} + STEP;
        reduced  = advanced - divisor;
        wrap     = (advanced >= divisor);
        phase_d  = wrap ? reduced[ACC_W-1:0] : advanced[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else begin
            phase <= phase_d;
        end
    end

endmodule

// File: rtl/clkdiv_seq.sv
// Two-state pulse sequencer; the enable masks the output only.
module clkdiv_seq
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic wrap,
    input  logic sm_en,
    output logic tick
);

    ph_state_e state_q;
    ph_state_e state_d;

    always_comb begin
        state_d = PH_ACCUM;
        unique case (state_q)
            PH_ACCUM: state_d = wrap ? PH_FIRE : PH_ACCUM;
            PH_FIRE:  state_d = wrap ? PH_FIRE : PH_ACCUM;
            default:  state_d = PH_ACCUM;
        endcase
        if (restart) begin
            state_d = PH_ACCUM;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ACCUM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_ACCUM: tick = 1'b0;
            PH_FIRE:  tick = sm_en;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/frac_clken_div.sv
module frac_clken_div #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    localparam int ACC_W = INT_W + FRAC_W,
    localparam int DIV_W = ACC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              restart,
    input  logic              sm_en,
    output logic              tick,
    output logic [ACC_W-1:0]  phase
);

    logic [DIV_W-1:0] divisor;
    logic             wrap;

    clkdiv_norm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) norm_i (
        .div_int  (div_int),
        .div_frac (div_frac),
        .divisor  (divisor)
    );

    clkdiv_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) accum_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .divisor (divisor),
        .phase   (phase),
        .wrap    (wrap)
    );

    clkdiv_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .wrap    (wrap),
        .sm_en   (sm_en),
        .tick    (tick)
    );

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8,
    localparam int ACC_W = INT_W + FRAC_W,
    localparam int DIV_W = ACC_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              restart,
    input logic              sm_en,
    input logic              tick,
    input logic [ACC_W-1:0]  phase
);

    logic [DIV_W-1:0] dval;
    logic [DIV_W-1:0] sum;
    logic [ACC_W-1:0] sum_lo;
    logic [ACC_W-1:0] left;

    always_comb begin
        dval   = (div_int == '0) ? (DIV_W'(1) << ACC_W) : DIV_W'(int'(div_int) * 256 + int'(div_frac));
        sum    = DIV_W'(phase) + (DIV_W'(1) << FRAC_W);
        sum_lo = sum[ACC_W-1:0];
        left   = ACC_W'(sum - dval);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase == '0) && !tick);

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == '0) && !tick);

    // R5
    enable_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !sm_en |-> !tick);

    // R2
    no_wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && (sum < dval)) |=> (phase == $past(sum_lo)) && !tick);

    // R2
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && (sum >= dval)) |=> (phase == $past(left)) && (tick == sm_en));

endmodule

bind frac_clken_div clkdiv_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .div_int  (div_int),
    .div_frac (div_frac),
    .restart  (restart),
    .sm_en    (sm_en),
    .tick     (tick),
    .phase    (phase)
);

// File: tb/frac_clken_div_tb_top.sv
`timescale 1ns/1ps
module frac_clken_div_tb_top;

    localparam int INT_W  = 16;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = INT_W + FRAC_W;

    typedef struct {
        logic        tick;
        int unsigned ph;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [INT_W-1:0]  div_int = '0;
    logic [FRAC_W-1:0] div_frac = '0;
    logic              restart = 1'b0;
    logic              b_restart = 1'b0;
    logic              sm_en = 1'b0;
    logic              tick, b_tick;
    logic [ACC_W-1:0]  phase, b_phase;

    int total = 0;
    int bad = 0;
    bit lock_chk = 1'b0;
    bit done = 1'b0;
    exp_t q[$];

    int unsigned m_ph = 0;
    int unsigned nxt_int = 0;
    int unsigned nxt_frac = 0;

    always #5 clk = ~clk;

    frac_clken_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst(rst), .div_int(div_int), .div_frac(div_frac),
        .restart(restart), .sm_en(sm_en), .tick(tick), .phase(phase)
    );

    frac_clken_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut_b (
        .clk(clk), .rst(rst), .div_int(div_int), .div_frac(div_frac),
        .restart(b_restart), .sm_en(sm_en), .tick(b_tick), .phase(b_phase)
    );

    // Driver: sets inputs for the next edge and queues the expected result.
    task automatic step(input bit rst_v, input bit rs_v, input bit brs_v,
                        input bit en_v, input string tag);
        exp_t e;
        int unsigned d;
        int unsigned s;
        bit raw;
        @(negedge clk);
        rst       = rst_v;
        restart   = rs_v;
        b_restart = brs_v;
        sm_en     = en_v;
        div_int   = INT_W'(nxt_int);
        div_frac  = FRAC_W'(nxt_frac);
        if (rst_v || rs_v) begin
            m_ph = 0;
            raw  = 1'b0;
        end else begin
            d = (nxt_int == 0) ? (32'd1 << 24) : (nxt_int * 256 + nxt_frac);
            s = m_ph + 256;
            if (s >= d) begin
                raw  = 1'b1;
                m_ph = s - d;
            end else begin
                raw  = 1'b0;
                m_ph = s;
            end
        end
        e.tick = raw & en_v;
        e.ph   = m_ph;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input bit en_v, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, en_v, tag);
    endtask

    // Monitor: compares after each edge, away from it.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (tick !== e.tick || int'(phase) != int'(e.ph)) begin
                    bad++;
                    $display("FAIL %s: tick=%0b phase=%0d expected tick=%0b phase=%0d",
                             e.tag, tick, phase, e.tick, e.ph);
                end
            end
            if (lock_chk) begin
                total++;
                if (tick !== b_tick || phase !== b_phase) begin
                    bad++;
                    $display("FAIL R7: b tick=%0b phase=%0d expected tick=%0b phase=%0d",
                             b_tick, b_phase, tick, phase);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, with a divisor that would pulse every cycle
        nxt_int = 1; nxt_frac = 0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R1");

        // R2: whole divisor 2.0
        nxt_int = 2; nxt_frac = 0;
        run(8, 1'b1, "R2");
        // R2: fractional divisor 1.5, dut_b restarted off-phase
        nxt_int = 1; nxt_frac = 128;
        step(1'b0, 1'b0, 1'b1, 1'b1, "R2");
        run(9, 1'b1, "R2");
        // R4: divisor 1.0 pulses every cycle
        nxt_int = 1; nxt_frac = 0;
        run(6, 1'b1, "R4");
        // R5: enable low masks pulses, phase keeps moving
        nxt_int = 2; nxt_frac = 128;
        run(6, 1'b0, "R5");
        run(5, 1'b1, "R5");
        // R6: restart mid-run, then restart on a would-be pulse
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        run(5, 1'b1, "R6");
        nxt_int = 1; nxt_frac = 0;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        run(2, 1'b1, "R6");
        // R8: divisor change on the fly without restart
        nxt_int = 3; nxt_frac = 0;
        run(2, 1'b1, "R8");
        nxt_int = 1; nxt_frac = 64;
        run(8, 1'b1, "R8");
        // R7: common restart brings both instances into lockstep
        nxt_int = 2; nxt_frac = 192;
        step(1'b0, 1'b1, 1'b1, 1'b1, "R7");
        @(posedge clk); #3; lock_chk = 1'b1;
        run(12, 1'b1, "R7");
        nxt_int = 1; nxt_frac = 200;
        run(8, 1'b1, "R7");
        // R3: zero whole part with nonzero fraction means 65536 exactly
        nxt_int = 0; nxt_frac = 85;
        step(1'b0, 1'b1, 1'b1, 1'b1, "R3");
        run(65540, 1'b1, "R3");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        lock_chk = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule